// File: doc/BRIEF.md
# Equal-Frequency Link Receive Synchronizer

This block sits at the receive end of a point-to-point link whose sender forwards its own clock with the data. The forwarded clock and the local receive clock run at the same frequency. The phase between them is fixed but not known. Every forwarded-clock cycle, the incoming word and its valid bit are stored into the next slot of a four-slot ring. On every receive-clock cycle, a read pointer picks one slot through a four-way multiplexer and registers it onto the output. The read pointer trails the write pointer by a fixed number of slots, so that each slot is read well clear of the moment it is written.

The trailing distance is chosen while the receive domain is held in reset. A one-slot lag gives the lowest latency. A two-slot lag gives the widest tolerance to the phase between the clocks. The write pointer is passed into the receive domain as a Gray code through a flop synchronizer. If the read pointer ever reaches the slot that the write side is about to fill, as seen through that synchronizer, a sticky error flag is set. A valid bit travels with each slot, so a slot that was never written, or was written with no valid word, always reaches the output as an idle cycle with zero data.

Top module: `meso_link_sync`

## Requirements
- R1: After a rising receive-clock edge sampled with rx_rst_n low, rx_valid is 0, rx_data is all zeros and rx_err is 0.
- R2: Counting from the first rising forwarded-clock edge sampled with tx_rst_n high, forwarded edge j stores {tx_valid, tx_data} into slot j mod 4. The slot order is 0, 1, 2, 3 and then wraps. A slot is written on every edge, whatever the value of tx_valid.
- R3: rx_err becomes 1 after receive edge k when k is at least SYNC_STAGES and the read slot used at edge k equals the synchronized write pointer plus SYNC_STAGES-1, modulo 4. Once set, it stays 1 until the next receive reset.
- R4: Counting from the first rising receive edge sampled with rx_rst_n high, edge k registers slot (k - lag) mod 4. When each receive edge trails its forwarded edge by less than one period, the word stored at forwarded edge j is presented after receive edge j + lag.
- R5: lat_fast = 1 selects a lag of one slot and lat_fast = 0 selects a lag of two slots. The value is taken only while rx_rst_n is low. Changing lat_fast while the receive domain runs has no effect.
- R6: When the selected slot holds a clear valid bit, rx_valid is 0 and rx_data is all zeros.
- R7: A forwarded-clock edge with tx_rst_n low clears the valid bit of all four slots and returns the write pointer to slot 0.
- R8: The write pointer crosses into the receive domain as a 2-bit Gray code. It changes by at most one bit per forwarded edge and passes through SYNC_STAGES receive-clock flops (default 2) before it is compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Clock forwarded with the link data |
| tx_rst_n | input | 1 | Active-low synchronous reset, forwarded-clock domain |
| tx_valid | input | 1 | Incoming word is valid |
| tx_data | input | DATA_W (38) | Incoming link word |
| rx_clk | input | 1 | Local receive clock, same frequency as tx_clk |
| rx_rst_n | input | 1 | Active-low synchronous reset, receive domain |
| lat_fast | input | 1 | 1 selects a one-slot lag, 0 a two-slot lag; sampled in reset |
| rx_valid | output | 1 | Registered output word is valid |
| rx_data | output | DATA_W (38) | Registered output word, zero when not valid |
| rx_err | output | 1 | Sticky pointer-collision flag |

## Verification
A word driven before forwarded edge j is due on the outputs after receive edge j + lag. This counts the slot register on the write side and the output register on the read side. The error flag is due one receive edge after the compare that detects the collision. That compare sees the write pointer as it stood SYNC_STAGES receive edges earlier. The bench keeps its own slot array, write count and per-edge history of that count. It updates them on the rising edges that the design also uses. It compares the outputs on the following falling receive edge, so every expected value already includes both registers and the synchronizer depth. Explicit checks cover the first-word timing for each lag, a lag change outside reset, a reset of the forwarded domain alone, and a stall of the forwarded clock.

// File: rtl/msync_pkg.sv
package msync_pkg;

    localparam int RING_SLOTS = 4;
    localparam int RING_PTR_W = $clog2(RING_SLOTS);

    typedef logic [RING_PTR_W-1:0] ring_ptr_t;
    typedef logic [RING_SLOTS-1:0] ring_strobe_t;

    function automatic ring_ptr_t to_gray(input ring_ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ring_ptr_t from_gray(input ring_ptr_t g);
        ring_ptr_t b;
        b[RING_PTR_W-1] = g[RING_PTR_W-1];
        for (int i = RING_PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/msync_wr_fsm.sv
module msync_wr_fsm
    import msync_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    output ring_strobe_t strobe_o,
    output ring_ptr_t    gray_o
);

    typedef struct packed {
        ring_strobe_t strobe;
        ring_ptr_t    gray;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        // rotate the one-hot write strobe to the next slot
        st_d.strobe = {st_q.strobe[RING_SLOTS-2:0], st_q.strobe[RING_SLOTS-1]};
        // published pointer steps in Gray code so the far side sees one bit move
        st_d.gray   = to_gray(ring_ptr_t'(from_gray(st_q.gray) + 1'b1));
        if (!rst_n) begin
            st_d.strobe = ring_strobe_t'(1);
            st_d.gray   = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;
    assign gray_o   = st_q.gray;

endmodule

// File: rtl/msync_slot_ring.sv
module msync_slot_ring
    import msync_pkg::*;
#(
    parameter int DATA_W = 38
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  ring_strobe_t                         strobe_i,
    input  logic                                 wr_valid_i,
    input  logic [DATA_W-1:0]                    wr_data_i,
    output logic [RING_SLOTS-1:0]                slot_valid_o,
    output logic [RING_SLOTS-1:0][DATA_W-1:0]    slot_data_o
);

    typedef struct packed {
        logic [RING_SLOTS-1:0]             valid;
        logic [RING_SLOTS-1:0][DATA_W-1:0] data;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < RING_SLOTS; s++) begin
            if (strobe_i[s]) begin
                st_d.valid[s] = wr_valid_i;
                st_d.data[s]  = wr_data_i;
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign slot_valid_o = st_q.valid;
    assign slot_data_o  = st_q.data;

endmodule

// File: rtl/msync_rd_fsm.sv
module msync_rd_fsm
    import msync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LAG_FAST    = 1,
    parameter int LAG_SAFE    = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lat_fast_i,
    input  ring_ptr_t wr_gray_i,
    output ring_ptr_t rd_ptr_o,
    output logic      err_o
);

    localparam int                ARM_W      = $clog2(SYNC_STAGES + 1);
    localparam logic [ARM_W-1:0]  ARM_MAX    = ARM_W'(SYNC_STAGES);
    localparam ring_ptr_t         START_FAST = ring_ptr_t'(RING_SLOTS - LAG_FAST);
    localparam ring_ptr_t         START_SAFE = ring_ptr_t'(RING_SLOTS - LAG_SAFE);
    // synchronized pointer is SYNC_STAGES-1 slots behind the slot in flight
    localparam ring_ptr_t         GUARD      = ring_ptr_t'(SYNC_STAGES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][RING_PTR_W-1:0] sync;
        ring_ptr_t                              rd;
        logic [ARM_W-1:0]                       arm;
        logic                                   err;
    } rd_state_t;

    rd_state_t st_d, st_q;
    ring_ptr_t wr_seen;
    logic      armed;
    logic      hazard;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = wr_gray_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.rd = ring_ptr_t'(st_q.rd + 1'b1);

        wr_seen = from_gray(st_q.sync[SYNC_STAGES-1]);
        armed   = (st_q.arm == ARM_MAX);
        hazard  = armed && (st_q.rd == ring_ptr_t'(wr_seen + GUARD));

        if (!armed) begin
            st_d.arm = ARM_W'(st_q.arm + 1'b1);
        end
        if (hazard) begin
            st_d.err = 1'b1;
        end

        if (!rst_n) begin
            st_d    = '0;
            st_d.rd = lat_fast_i ? START_FAST : START_SAFE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_ptr_o = st_q.rd;
    assign err_o    = st_q.err;

endmodule

// File: rtl/msync_out_mux.sv
module msync_out_mux
    import msync_pkg::*;
#(
    parameter int DATA_W = 38
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  ring_ptr_t                         rd_ptr_i,
    input  logic [RING_SLOTS-1:0]             slot_valid_i,
    input  logic [RING_SLOTS-1:0][DATA_W-1:0] slot_data_i,
    output logic                              out_valid_o,
    output logic [DATA_W-1:0]                 out_data_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t st_d, st_q;

    logic [RING_SLOTS-1:0]             hit;
    logic [RING_SLOTS-1:0][DATA_W-1:0] masked;
    logic [DATA_W-1:0]                 picked;

    for (genvar g = 0; g < RING_SLOTS; g++) begin : g_leg
        assign hit[g]    = (rd_ptr_i == ring_ptr_t'(g)) && slot_valid_i[g];
        assign masked[g] = {DATA_W{hit[g]}} & slot_data_i[g];
    end

    always_comb begin
        picked = '0;
        for (int s = 0; s < RING_SLOTS; s++) begin
            picked = picked | masked[s];
        end
        st_d.valid = |hit;
        st_d.data  = picked;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid_o = st_q.valid;
    assign out_data_o  = st_q.data;

endmodule

// File: rtl/meso_link_sync.sv
module meso_link_sync
    import msync_pkg::*;
#(
    parameter int DATA_W      = 38,
    parameter int SYNC_STAGES = 2,
    parameter int LAG_FAST    = 1,
    parameter int LAG_SAFE    = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              lat_fast,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_err
);

    ring_strobe_t                      wr_strobe;
    ring_ptr_t                         wr_gray;
    ring_ptr_t                         rd_ptr;
    logic [RING_SLOTS-1:0]             slot_valid;
    logic [RING_SLOTS-1:0][DATA_W-1:0] slot_data;

    msync_wr_fsm u_wr (
        .clk      (tx_clk),
        .rst_n    (tx_rst_n),
        .strobe_o (wr_strobe),
        .gray_o   (wr_gray)
    );

    msync_slot_ring #(.DATA_W(DATA_W)) u_ring (
        .clk          (tx_clk),
        .rst_n        (tx_rst_n),
        .strobe_i     (wr_strobe),
        .wr_valid_i   (tx_valid),
        .wr_data_i    (tx_data),
        .slot_valid_o (slot_valid),
        .slot_data_o  (slot_data)
    );

    msync_rd_fsm #(
        .SYNC_STAGES (SYNC_STAGES),
        .LAG_FAST    (LAG_FAST),
        .LAG_SAFE    (LAG_SAFE)
    ) u_rd (
        .clk        (rx_clk),
        .rst_n      (rx_rst_n),
        .lat_fast_i (lat_fast),
        .wr_gray_i  (wr_gray),
        .rd_ptr_o   (rd_ptr),
        .err_o      (rx_err)
    );

    msync_out_mux #(.DATA_W(DATA_W)) u_mux (
        .clk          (rx_clk),
        .rst_n        (rx_rst_n),
        .rd_ptr_i     (rd_ptr),
        .slot_valid_i (slot_valid),
        .slot_data_i  (slot_data),
        .out_valid_o  (rx_valid),
        .out_data_o   (rx_data)
    );

endmodule

// File: rtl/meso_link_sync_chk.sv
module meso_link_sync_chk
    import msync_pkg::*;
#(
    parameter int DATA_W = 38
) (
    input logic              tx_clk,
    input logic              tx_rst_n,
    input logic              rx_clk,
    input logic              rx_rst_n,
    input ring_strobe_t      strobe,
    input ring_ptr_t         wr_gray,
    input ring_ptr_t         rd_ptr,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_err
);

    ring_strobe_t strobe_rot;
    assign strobe_rot = {strobe[RING_SLOTS-2:0], strobe[RING_SLOTS-1]};

    assert_reset_quiet_R1: assert property (@(posedge rx_clk)
        !rx_rst_n |=> (!rx_valid && rx_data == '0 && !rx_err));

    assert_strobe_onehot_R2: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $onehot(strobe));

    assert_strobe_rotates_R2: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $past(tx_rst_n) |-> strobe == $past(strobe_rot));

    assert_err_sticky_R3: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        rx_err |=> rx_err);

    assert_rd_steps_R4: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        $past(rx_rst_n) |-> rd_ptr == ring_ptr_t'($past(rd_ptr) + 1'b1));

    assert_idle_zero_R6: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
        !rx_valid |-> rx_data == '0);

    assert_gray_step_R8: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
        $past(tx_rst_n) |-> $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

bind meso_link_sync meso_link_sync_chk #(.DATA_W(DATA_W)) u_chk (
    .tx_clk   (tx_clk),
    .tx_rst_n (tx_rst_n),
    .rx_clk   (rx_clk),
    .rx_rst_n (rx_rst_n),
    .strobe   (wr_strobe),
    .wr_gray  (wr_gray),
    .rd_ptr   (rd_ptr),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_err   (rx_err)
);

// File: tb/meso_link_sync_tb.sv
`timescale 1ns/1ps
module meso_link_sync_tb;

    localparam int DW = 38;

    logic tx_raw = 1'b0;
    logic tx_en  = 1'b1;
    logic rx_clk = 1'b0;
    logic tx_clk;
    assign tx_clk = tx_raw & tx_en;

    initial forever #2 tx_raw = ~tx_raw;
    initial begin
        #1;
        forever #2 rx_clk = ~rx_clk;
    end

    logic          tx_rst_n = 1'b0;
    logic          rx_rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data  = '0;
    logic          lat_fast = 1'b0;
    logic          rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_err;

    meso_link_sync u_dut (
        .tx_clk   (tx_clk),
        .tx_rst_n (tx_rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .rx_clk   (rx_clk),
        .rx_rst_n (rx_rst_n),
        .lat_fast (lat_fast),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_err   (rx_err)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return {6'(i * 7 + 3), 32'(i * 32'h9E3779B1 + 32'h1234)};
    endfunction

    // behavioural reference: slot contents, write count, per-edge write count history
    logic [DW:0]   m_slot [4];
    int            m_txcnt = 0;
    int            m_k     = 0;
    int            m_lag   = 2;
    int            m_hist [$];
    logic          e_valid = 1'b0;
    logic [DW-1:0] e_data  = '0;
    logic          e_err   = 1'b0;
    bit            cmp_on  = 1'b0;

    always @(posedge tx_clk) begin
        if (!tx_rst_n) begin
            for (int s = 0; s < 4; s++) m_slot[s][DW] = 1'b0;
            m_txcnt = 0;
        end else begin
            m_slot[m_txcnt % 4] = {tx_valid, tx_data};
            m_txcnt++;
        end
    end

    always @(posedge rx_clk) begin
        cmp_on = 1'b1;
        if (!rx_rst_n) begin
            m_lag = lat_fast ? 1 : 2;
            m_k   = 0;
            m_hist.delete();
            e_valid = 1'b0;
            e_data  = '0;
            e_err   = 1'b0;
        end else begin
            int slot;
            slot    = (m_k - m_lag + 4) % 4;
            e_valid = (m_slot[slot][DW] === 1'b1);
            e_data  = e_valid ? m_slot[slot][DW-1:0] : '0;
            if (m_k >= 2) begin
                if (slot == (m_hist[m_k-2] + 1) % 4) e_err = 1'b1;
            end
            m_hist.push_back(m_txcnt % 4);
            m_k++;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge rx_clk) begin
        if (cmp_on) begin
            chk(rx_valid === e_valid, "R1 R4 R6 valid", 64'(rx_valid), 64'(e_valid));
            chk(rx_data === e_data, "R1 R2 R4 R6 data", 64'(rx_data), 64'(e_data));
            chk(rx_err === e_err, "R1 R3 R8 err", 64'(rx_err), 64'(e_err));
        end
    end

    task automatic reset_all(input bit fast);
        @(negedge rx_clk);
        tx_rst_n = 1'b0;
        rx_rst_n = 1'b0;
        lat_fast = fast;
        tx_valid = 1'b0;
        tx_data  = '0;
        repeat (4) @(negedge rx_clk);
        chk(!rx_valid && rx_data == '0 && !rx_err, "R1 reset outputs",
            64'({rx_valid, rx_err}), 64'(0));
        tx_valid = 1'b1;
        tx_data  = pat(1000);
        tx_rst_n = 1'b1;
        rx_rst_n = 1'b1;
    endtask

    task automatic stream(input int n, input int seed, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge tx_raw);
            tx_valid = gaps ? (i % 3 != 1) : 1'b1;
            tx_data  = pat(seed + i);
        end
    endtask

    task automatic first_word(input int lag_v, input logic [DW-1:0] w);
        repeat (lag_v) @(posedge rx_clk);
        @(negedge rx_clk);
        chk(!rx_valid, "R5 R6 nothing before lag", 64'(rx_valid), 64'(0));
        @(posedge rx_clk);
        @(negedge rx_clk);
        chk(rx_valid && rx_data == w, "R4 R5 first word timing", 64'(rx_data), 64'(w));
    endtask

    initial begin
        repeat (150000) @(posedge rx_clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // two-slot lag
        reset_all(1'b0);
        fork
            stream(40, 0, 1'b0);
            first_word(2, pat(1000));
        join
        chk(!rx_err, "R3 no alarm, lag two", 64'(rx_err), 64'(0));

        // lat_fast moved outside reset must not alter timing (R5); idle gaps (R6)
        lat_fast = 1'b1;
        stream(30, 100, 1'b1);
        lat_fast = 1'b0;

        // one-slot lag
        reset_all(1'b1);
        fork
            stream(40, 200, 1'b0);
            first_word(1, pat(1000));
        join
        chk(!rx_err, "R3 no alarm, lag one", 64'(rx_err), 64'(0));
        stream(20, 300, 1'b1);

        // forwarded-domain reset alone clears slots (R7)
        @(negedge rx_clk);
        tx_rst_n = 1'b0;
        repeat (2) @(negedge rx_clk);
        chk(!rx_valid, "R7 slots cleared", 64'(rx_valid), 64'(0));
        @(negedge rx_clk);
        tx_rst_n = 1'b1;
        stream(10, 400, 1'b0);

        // forwarded clock stalls: pointers collide (R3)
        reset_all(1'b0);
        stream(20, 500, 1'b0);
        @(negedge tx_raw);
        tx_en = 1'b0;
        repeat (8) @(negedge tx_raw);
        tx_en = 1'b1;
        repeat (3) @(negedge rx_clk);
        chk(rx_err, "R3 stall raises flag", 64'(rx_err), 64'(1));
        stream(10, 600, 1'b0);
        @(negedge rx_clk);
        chk(rx_err, "R3 flag sticky", 64'(rx_err), 64'(1));

        // reset clears the flag (R1)
        reset_all(1'b1);
        stream(8, 700, 1'b0);
        @(negedge rx_clk);
        chk(!rx_err, "R1 R3 flag cleared by reset", 64'(rx_err), 64'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule